// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel with one counting element. A configuration write selects one of six waveform behaviours and whether the counter works in plain binary or in four-decade BCD. A separate load strobe delivers a full-width initial count. A sampled `gate` input either pauses counting or starts it on a rising edge, depending on the behaviour. The single `out` pin carries the resulting waveform: a terminal-count flag, a one-shot pulse, a rate tick, a square wave, or a one-cycle strobe.

The live contents of the counting element and a pending-count flag are always visible for readback. Byte sequencing and address decoding are left to the surrounding logic. `gate` is treated as a signal synchronous to `clk`, and its rising edge is detected against the value it held on the previous edge. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 0, `count_val` is 0 and `null_count` is 1, with behaviour code 0 and binary counting selected.
- R2: Behaviour 0 (terminal flag): a configuration write drives `out` low. The loaded count reaches `count_val` one clock after the load edge and then decrements once per clock. `out` rises on the edge where the count becomes 0 and stays high while the counter wraps through 0xFFFF.
- R3: In behaviour 0, `gate` low freezes the count and `gate` high resumes it. A new load in the middle of a countdown halts counting on its own edge and drives `out` low. The new value is transferred on the following edge.
- R4: Behaviour 1 (one-shot): `out` idles high. A rising `gate`, once a count exists, loads the count and drives `out` low on that edge. `out` returns high N clocks later. A later rising edge reloads and extends the pulse. The level of `gate` does not affect counting.
- R5: In behaviour 1, a count written during a pulse leaves the running pulse unchanged and is used at the next trigger.
- R6: Behaviour 2 (rate): with a count N of at least 2, the counter runs N..1 and reloads from the count register on the edge after it reads 1, repeating every N clocks. `out` is low exactly while the count reads 1. A rewrite while running is used only at the next reload.
- R7: Behaviour 3 (square): with N of at least 2, `out` is high for ceil(N/2) clocks and low for floor(N/2) clocks, in a period of N. The counter steps by 2, or by 1 from an odd value.
- R8: Behaviour 4 (software strobe): counting starts one clock after a load. `out` is low for exactly one clock on the edge where the count becomes 0, then high. `gate` low freezes the count.
- R9: Behaviour 5 (hardware strobe): a rising `gate` loads the count, and `out` is low for exactly one clock N edges later. A further rising edge restarts the count.
- R10: Configuration codes 6 and 7 behave exactly as codes 2 and 3.
- R11: A loaded value of 0 counts as 65536 in binary and as 10000 in BCD. In BCD, decrementing borrows across four decimal digits, for example 0x0100 to 0x0099 and 0x0000 to 0x9999.
- R12: In behaviours 2 and 3, `gate` low freezes the count and forces `out` high. A rising `gate` reloads the count register and starts again with `out` high.
- R13: `null_count` goes to 1 on a load or configuration write and returns to 0 on the edge that transfers the count into the counting element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe; takes priority over `load_wr` |
| cfg_mode | input | 3 | Behaviour code 0..7 |
| cfg_bcd | input | 1 | 1 selects four-decade BCD counting |
| load_wr | input | 1 | Count load strobe |
| load_val | input | 16 | Initial count value |
| gate | input | 1 | Synchronous gate: level pause or rising-edge trigger |
| out | output | 1 | Channel waveform output |
| count_val | output | 16 | Live contents of the counting element |
| null_count | output | 1 | 1 while a written count is not yet transferred |

## Verification
The bench builds the channel with its default of four decades, which gives a 16-bit counting element. At that width, the zero-means-maximum rule can be followed through a complete binary period of 65536 clocks and a complete BCD period of 10000 clocks in one run. The same width keeps the decade borrow chain four digits long, so a borrow that crosses every digit is reachable from a single load of zero. Randomly chosen counts between 2 and 41 cover both parities of the square-wave split and rate periods of many lengths.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pit_mode_e;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_DEC1 = 2'd2,
    CMD_DEC2 = 2'd3
  } cnt_cmd_e;

endpackage

// File: rtl/pit_gate_det.sv
module pit_gate_det (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cnt_cmd_e            cmd,
  input  logic                bcd,
  input  logic [4*DIGITS-1:0] load_val,
  output logic [4*DIGITS-1:0] cnt
);

  localparam int W = 4 * DIGITS;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  function automatic logic [W-1:0] dec_by(input logic [W-1:0] v, input logic dec_bcd,
                                          input logic [1:0] step);
    logic [W-1:0] r;
    logic [3:0]   dig;
    logic [3:0]   brw;
    r = v;
    if (!dec_bcd) begin
      r = v - {{(W-2){1'b0}}, step};
    end else begin
      brw = {2'b00, step};
      for (int i = 0; i < DIGITS; i++) begin
        dig = v[4*i +: 4];
        if (dig >= brw) begin
          r[4*i +: 4] = dig - brw;
          brw = 4'd0;
        end else begin
          r[4*i +: 4] = dig + 4'd10 - brw;
          brw = 4'd1;
        end
      end
    end
    return r;
  endfunction

  always_comb begin
    unique case (cmd)
      CMD_LOAD: cnt_d = load_val;
      CMD_DEC1: cnt_d = dec_by(cnt_q, bcd, 2'd1);
      CMD_DEC2: cnt_d = dec_by(cnt_q, bcd, 2'd2);
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cmd != CMD_HOLD)  cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_hold_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=> $stable(cnt_q));

  assert_load_transfers_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pit_mode_ctrl.sv
module pit_mode_ctrl
  import pit_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [2:0]   cfg_mode,
  input  logic         cfg_bcd,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  input  logic         gate,
  input  logic         gate_rise,
  input  logic [W-1:0] cnt,
  output cnt_cmd_e     cmd,
  output logic [W-1:0] cmd_val,
  output logic         bcd,
  output logic         out,
  output logic         null_count
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  pit_mode_e    mode_q, mode_d, cfg_eff;
  logic         bcd_q, bcd_d;
  logic [W-1:0] cr_q, cr_d;
  logic         out_q, out_d;
  logic         null_q, null_d;
  logic         live_q, live_d;
  logic         armed_q, armed_d;
  logic         pend_q, pend_d;
  logic         have_q, have_d;
  logic [W-1:0] low_val;
  logic         is_strobe;

  assign cfg_eff   = cfg_mode[1] ? pit_mode_e'({1'b0, cfg_mode[1:0]}) : pit_mode_e'(cfg_mode);
  assign low_val   = {cr_q[W-1:1], 1'b0};
  assign is_strobe = (mode_q == M_SWSTROBE) || (mode_q == M_HWSTROBE);

  always_comb begin
    mode_d  = mode_q;
    bcd_d   = bcd_q;
    cr_d    = cr_q;
    out_d   = out_q;
    null_d  = null_q;
    live_d  = live_q;
    armed_d = armed_q;
    pend_d  = pend_q;
    have_d  = have_q;
    cmd     = CMD_HOLD;
    cmd_val = cr_q;
    if (cfg_wr) begin
      mode_d  = cfg_eff;
      bcd_d   = cfg_bcd;
      out_d   = (cfg_eff != M_TERM);
      live_d  = 1'b0;
      armed_d = 1'b0;
      pend_d  = 1'b0;
      have_d  = 1'b0;
      null_d  = 1'b1;
    end else begin
      if (is_strobe && !out_q) out_d = 1'b1;
      if (load_wr && (mode_q == M_TERM || mode_q == M_SWSTROBE)) begin
        pend_d  = 1'b1;
        live_d  = 1'b0;
        armed_d = 1'b0;
        if (mode_q == M_TERM) out_d = 1'b0;
      end else if (load_wr && (mode_q == M_RATE || mode_q == M_SQUARE) && !live_q) begin
        pend_d = 1'b1;
      end else if (pend_q) begin
        cmd     = CMD_LOAD;
        pend_d  = 1'b0;
        live_d  = 1'b1;
        armed_d = 1'b1;
        null_d  = 1'b0;
      end else begin
        case (mode_q)
          M_TERM, M_SWSTROBE: begin
            if (live_q && gate) begin
              cmd = CMD_DEC1;
              if (armed_q && cnt == ONE) begin
                armed_d = 1'b0;
                out_d   = (mode_q == M_TERM);
              end
            end
          end
          M_ONESHOT, M_HWSTROBE: begin
            if (gate_rise && have_q) begin
              cmd     = CMD_LOAD;
              live_d  = 1'b1;
              armed_d = 1'b1;
              null_d  = 1'b0;
              if (mode_q == M_ONESHOT) out_d = 1'b0;
            end else if (live_q) begin
              cmd = CMD_DEC1;
              if (armed_q && cnt == ONE) begin
                armed_d = 1'b0;
                out_d   = (mode_q == M_ONESHOT);
              end
            end
          end
          M_RATE: begin
            if (live_q) begin
              if (!gate) begin
                out_d = 1'b1;
              end else if (gate_rise || cnt == ONE) begin
                cmd    = CMD_LOAD;
                out_d  = 1'b1;
                null_d = 1'b0;
              end else begin
                cmd = CMD_DEC1;
                if (cnt == TWO) out_d = 1'b0;
              end
            end
          end
          M_SQUARE: begin
            if (live_q) begin
              if (!gate) begin
                out_d = 1'b1;
              end else if (gate_rise) begin
                cmd    = CMD_LOAD;
                out_d  = 1'b1;
                null_d = 1'b0;
              end else if (cnt == TWO) begin
                cmd     = CMD_LOAD;
                cmd_val = out_q ? low_val : cr_q;
                out_d   = !out_q;
                null_d  = 1'b0;
              end else begin
                cmd = cnt[0] ? CMD_DEC1 : CMD_DEC2;
              end
            end
          end
          default: ;
        endcase
      end
      if (load_wr) begin
        cr_d   = load_val;
        null_d = 1'b1;
        have_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_TERM;
      bcd_q   <= 1'b0;
      cr_q    <= '0;
      out_q   <= 1'b0;
      null_q  <= 1'b1;
      live_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      bcd_q   <= bcd_d;
      cr_q    <= cr_d;
      out_q   <= out_d;
      null_q  <= null_d;
      live_q  <= live_d;
      armed_q <= armed_d;
      pend_q  <= pend_d;
      have_q  <= have_d;
    end
  end

  assign bcd        = bcd_q;
  assign out        = out_q;
  assign null_count = null_q;

  assert_cfg_term_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode == 3'd0) |=> !out_q);

  assert_oneshot_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && mode_q == M_ONESHOT && gate_rise && have_q) |=> !out_q);

  assert_strobe_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && is_strobe && !out_q) |=> out_q);

  assert_gate_forces_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && live_q && (mode_q == M_RATE || mode_q == M_SQUARE) && !gate) |=> out_q);

  assert_null_on_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr || cfg_wr) |=> null_q);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [2:0]          cfg_mode,
  input  logic                cfg_bcd,
  input  logic                load_wr,
  input  logic [4*DIGITS-1:0] load_val,
  input  logic                gate,
  output logic                out,
  output logic [4*DIGITS-1:0] count_val,
  output logic                null_count
);

  localparam int W = 4 * DIGITS;

  logic         rst_meta, rst_sn;
  logic         gate_rise;
  cnt_cmd_e     cmd;
  logic [W-1:0] cmd_val;
  logic         bcd;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  pit_gate_det u_gate (
    .clk       (clk),
    .rst_n     (rst_sn),
    .gate      (gate),
    .gate_rise (gate_rise)
  );

  pit_mode_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cfg_wr     (cfg_wr),
    .cfg_mode   (cfg_mode),
    .cfg_bcd    (cfg_bcd),
    .load_wr    (load_wr),
    .load_val   (load_val),
    .gate       (gate),
    .gate_rise  (gate_rise),
    .cnt        (cnt),
    .cmd        (cmd),
    .cmd_val    (cmd_val),
    .bcd        (bcd),
    .out        (out),
    .null_count (null_count)
  );

  pit_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sn),
    .cmd      (cmd),
    .bcd      (bcd),
    .load_val (cmd_val),
    .cnt      (cnt)
  );

  assign count_val = cnt;

endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_mode;
  logic        cfg_bcd;
  logic        load_wr;
  logic [15:0] load_val;
  logic        gate;
  logic        out;
  logic [15:0] count_val;
  logic        null_count;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .load_wr(load_wr), .load_val(load_val), .gate(gate),
    .out(out), .count_val(count_val), .null_count(null_count)
  );

  function automatic logic exp_rate_out(int i, int n);
    return ((i % n) == n - 1) ? 1'b0 : 1'b1;
  endfunction

  function automatic int exp_rate_cnt(int i, int n);
    return n - (i % n);
  endfunction

  function automatic logic exp_sq_out(int i, int n);
    return ((i % n) < (n + 1) / 2) ? 1'b1 : 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic [2:0] m, logic b);
    cfg_wr = 1'b1; cfg_mode = m; cfg_bcd = b;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic load(logic [15:0] v);
    load_wr = 1'b1; load_val = v;
    tick(1);
    load_wr = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic run_rate(string tag, int n);
    load(16'(n));
    tick(1);
    for (int i = 0; i < 3 * n; i++) begin
      chk({tag, " out"}, 32'(out), 32'(exp_rate_out(i, n)));
      chk({tag, " count"}, 32'(count_val), 32'(exp_rate_cnt(i, n)));
      tick(1);
    end
  endtask

  task automatic run_square(string tag, int n);
    load(16'(n));
    tick(1);
    for (int i = 0; i < 3 * n; i++) begin
      chk({tag, " out"}, 32'(out), 32'(exp_sq_out(i, n)));
      tick(1);
    end
  endtask

  task automatic run_term(int n);
    load(16'(n));
    tick(1);
    chk("R2 count loaded", 32'(count_val), 32'(n));
    tick(n - 1);
    chk("R2 out before zero", 32'(out), 32'd0);
    tick(1);
    chk("R2 out at zero", 32'(out), 32'd1);
  endtask

  task automatic run_strobe(int n);
    load(16'(n));
    tick(1);
    chk("R8 count loaded", 32'(count_val), 32'(n));
    tick(n - 1);
    chk("R8 out before zero", 32'(out), 32'd1);
    tick(1);
    chk("R8 strobe low", 32'(out), 32'd0);
    tick(1);
    chk("R8 strobe ends", 32'(out), 32'd1);
  endtask

  task automatic wait_low(string tag, int exp_i);
    int i = 0;
    while (out !== 1'b0 && i < 70000) begin
      tick(1);
      i++;
    end
    chk(tag, 32'(i), 32'(exp_i));
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_mode = 3'd0; cfg_bcd = 1'b0;
    load_wr = 1'b0; load_val = 16'd0; gate = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    chk("R1 out", 32'(out), 32'd0);
    chk("R1 count", 32'(count_val), 32'd0);
    chk("R1 null", 32'(null_count), 32'd1);

    // R2 / R13
    cfg(3'd0, 1'b0);
    chk("R2 cfg drives out low", 32'(out), 32'd0);
    gate = 1'b1;
    load(16'd7);
    chk("R13 null after load", 32'(null_count), 32'd1);
    tick(1);
    chk("R2 count transferred", 32'(count_val), 32'd7);
    chk("R13 null cleared", 32'(null_count), 32'd0);
    tick(6);
    chk("R2 out low at 1", 32'(out), 32'd0);
    tick(1);
    chk("R2 out high at 0", 32'(out), 32'd1);
    tick(3);
    chk("R2 wrap out", 32'(out), 32'd1);
    chk("R2 wrap count", 32'(count_val), 32'hFFFD);

    // R3
    load(16'd9);
    chk("R3 reload halts", 32'(count_val), 32'hFFFD);
    chk("R3 reload drives low", 32'(out), 32'd0);
    tick(1);
    chk("R3 new count", 32'(count_val), 32'd9);
    gate = 1'b0;
    tick(5);
    chk("R3 gate low freezes", 32'(count_val), 32'd9);
    gate = 1'b1;
    tick(2);
    chk("R3 gate high resumes", 32'(count_val), 32'd7);

    // R4 / R5
    gate = 1'b0;
    cfg(3'd1, 1'b0);
    chk("R4 idle high", 32'(out), 32'd1);
    load(16'd6);
    chk("R4 no trigger yet", 32'(out), 32'd1);
    chk("R13 null before trigger", 32'(null_count), 32'd1);
    tick(1);
    gate = 1'b1;
    tick(1);
    chk("R4 trigger low", 32'(out), 32'd0);
    chk("R4 trigger count", 32'(count_val), 32'd6);
    chk("R13 null after trigger", 32'(null_count), 32'd0);
    tick(5);
    chk("R4 pulse still low", 32'(out), 32'd0);
    tick(1);
    chk("R4 pulse ends", 32'(out), 32'd1);
    gate = 1'b0; tick(1); gate = 1'b1; tick(1);
    chk("R4 second trigger", 32'(count_val), 32'd6);
    tick(2);
    gate = 1'b0;
    tick(2);
    chk("R4 gate level ignored count", 32'(count_val), 32'd2);
    chk("R4 gate level ignored out", 32'(out), 32'd0);
    gate = 1'b1;
    tick(1);
    chk("R4 retrigger reload", 32'(count_val), 32'd6);
    load(16'd3);
    chk("R5 pulse unaffected", 32'(count_val), 32'd5);
    tick(4);
    chk("R5 old pulse low", 32'(out), 32'd0);
    tick(1);
    chk("R5 old pulse ends", 32'(out), 32'd1);
    gate = 1'b0; tick(1); gate = 1'b1; tick(1);
    chk("R5 new count on trigger", 32'(count_val), 32'd3);
    tick(2);
    chk("R5 new pulse low", 32'(out), 32'd0);
    tick(1);
    chk("R5 new pulse ends", 32'(out), 32'd1);

    // R6
    cfg(3'd2, 1'b0);
    run_rate("R6 rate n5", 5);
    cfg(3'd2, 1'b0);
    load(16'd8);
    tick(1);
    tick(2);
    chk("R6 mid count", 32'(count_val), 32'd6);
    load(16'd4);
    chk("R6 rewrite no effect", 32'(count_val), 32'd5);
    tick(4);
    chk("R6 low at 1", 32'(out), 32'd0);
    tick(1);
    chk("R6 new period count", 32'(count_val), 32'd4);
    chk("R6 new period out", 32'(out), 32'd1);
    tick(3);
    chk("R6 new period low", 32'(out), 32'd0);
    tick(1);

    // R12
    tick(1);
    chk("R12 running", 32'(count_val), 32'd3);
    gate = 1'b0;
    tick(1);
    chk("R12 rate forced high", 32'(out), 32'd1);
    tick(2);
    chk("R12 rate frozen", 32'(count_val), 32'd3);
    gate = 1'b1;
    tick(1);
    chk("R12 rate restart", 32'(count_val), 32'd4);
    tick(3);
    chk("R12 rate after restart", 32'(out), 32'd0);
    cfg(3'd3, 1'b0);
    load(16'd6);
    tick(1);
    tick(3);
    chk("R12 square low half", 32'(out), 32'd0);
    tick(1);
    chk("R12 square stepping", 32'(count_val), 32'd4);
    gate = 1'b0;
    tick(1);
    chk("R12 square forced high", 32'(out), 32'd1);
    chk("R12 square frozen", 32'(count_val), 32'd4);
    gate = 1'b1;
    tick(1);
    chk("R12 square restart", 32'(count_val), 32'd6);
    chk("R12 square restart out", 32'(out), 32'd1);

    // R7 / R10
    cfg(3'd3, 1'b0);
    run_square("R7 square odd", 7);
    cfg(3'd3, 1'b0);
    run_square("R7 square even", 8);
    cfg(3'd6, 1'b0);
    run_rate("R10 code 6", 4);
    cfg(3'd7, 1'b0);
    run_square("R10 code 7", 5);

    // R8
    cfg(3'd4, 1'b0);
    chk("R8 idle high", 32'(out), 32'd1);
    run_strobe(5);
    chk("R8 wraps", 32'(count_val), 32'hFFFF);
    load(16'd4);
    tick(1);
    chk("R8 reload", 32'(count_val), 32'd4);
    gate = 1'b0;
    tick(3);
    chk("R8 gate freeze", 32'(count_val), 32'd4);
    gate = 1'b1;
    tick(3);
    chk("R8 resume", 32'(count_val), 32'd1);
    tick(1);
    chk("R8 late strobe", 32'(out), 32'd0);
    tick(1);
    chk("R8 late strobe ends", 32'(out), 32'd1);

    // R9
    cfg(3'd5, 1'b0);
    gate = 1'b0;
    load(16'd6);
    tick(2);
    chk("R9 waits for trigger", 32'(out), 32'd1);
    gate = 1'b1;
    tick(1);
    chk("R9 trigger loads", 32'(count_val), 32'd6);
    tick(5);
    chk("R9 high before zero", 32'(out), 32'd1);
    tick(1);
    chk("R9 strobe low", 32'(out), 32'd0);
    tick(1);
    chk("R9 strobe ends", 32'(out), 32'd1);
    gate = 1'b0; tick(1); gate = 1'b1; tick(1);
    chk("R9 retrigger", 32'(count_val), 32'd6);

    // R11
    cfg(3'd0, 1'b0);
    load(16'd0);
    tick(2);
    chk("R11 binary zero wraps", 32'(count_val), 32'hFFFF);
    cfg(3'd0, 1'b1);
    load(16'h0000);
    tick(2);
    chk("R11 bcd zero", 32'(count_val), 32'h9999);
    load(16'h0100);
    tick(1);
    chk("R11 bcd load", 32'(count_val), 32'h0100);
    tick(1);
    chk("R11 bcd borrow", 32'(count_val), 32'h0099);
    cfg(3'd3, 1'b1);
    load(16'h0010);
    tick(2);
    chk("R11 bcd step two", 32'(count_val), 32'h0008);
    cfg(3'd2, 1'b0);
    load(16'd0);
    tick(1);
    wait_low("R11 binary 65536 period", 65535);
    cfg(3'd2, 1'b1);
    load(16'd0);
    tick(1);
    wait_low("R11 bcd 10000 period", 9999);

    // Random mix (R2 R6 R7 R8)
    for (int k = 0; k < 24; k++) begin
      int sel;
      int n;
      sel = int'($urandom % 4);
      n = 2 + int'($urandom % 40);
      case (sel)
        0: begin cfg(3'd0, 1'b0); run_term(n); end
        1: begin cfg(3'd2, 1'b0); run_rate("R6 random", n); end
        2: begin cfg(3'd3, 1'b0); run_square("R7 random", n); end
        default: begin cfg(3'd4, 1'b0); run_strobe(n); end
      endcase
    end

    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule